// File: doc/BRIEF.md
# Prioritized Local-to-PCI Address Window Translator

This block turns a local-bus address into a PCI bus address through three programmable windows. Each window is described by a pair of registers. The local register holds the window's local base and its enable. The translation register holds the PCI-side base, the size code and the access kind. A request is a local address presented with a valid strobe. One clock later the block returns the translated address, the access kind, a hit flag and the index of the window that matched.

Windows may overlap on purpose. When they do, the lowest-numbered enabled window that contains the address always wins. Software relies on this to hide a window: it enlarges window 0 from 256 MB to 512 MB so that it covers window 1, rewrites window 1 (for example as a 16 MB configuration window), and later shrinks window 0 again to uncover the restored window.

The response path is a three-state machine: `ST_IDLE`, `ST_HIT` and `ST_MISS`. From any state the machine moves on each clock as follows:
- with no request it takes the transition *quiet* to `ST_IDLE`;
- a request that some enabled window contains takes the transition *matched* to `ST_HIT`;
- a request that no enabled window contains takes the transition *unmatched* to `ST_MISS`.

Top module: `lbwin_xlate`

## Requirements
- R1: After reset every window is disabled: `rsp_valid` is 0, and any request is answered as a miss.
- R2: A request sampled on a clock edge is answered on the edge that follows it, with `rsp_valid` high for exactly that one cycle. Requests may arrive on consecutive cycles.
- R3: A window matches when it is enabled and the local address bits above the window size equal the corresponding bits of its local base. The size is 2^(24+n) bytes, where n = 0, 4, 5 or 6.
- R4: When several enabled windows match, the lowest index wins and its translation and kind are returned.
- R5: The translated address is the PCI base, masked to the window size, ORed with the offset of the address inside the window. The kind field is returned as programmed.
- R6: Size codes in `reg_wdata[1:0]` select the window length: 0 = 16 MB, 1 = 256 MB, 2 = 512 MB, 3 = 1 GB.
- R7: A window of kind 3 (configuration) is always 16 MB, whatever its size code. It passes address bits 23:2 through, which carry device (15:11), function (10:8) and register (7:2). It drives bits 1:0 as 00.
- R8: Kinds are encoded 0 = memory, 1 = prefetchable memory, 2 = I/O, 3 = configuration, 4 = message unit. Window 2 accepts only kinds 2 and 4; any other kind written to it is stored as 2. Windows 0 and 1 store any kind.
- R9: A register write takes effect for requests sampled on later edges. A request sampled on the same edge as the write uses the old values. A write whose `reg_win` is 3 changes nothing.
- R10: On a miss the block returns `rsp_hit` = 0, `rsp_win` = 3, `rsp_addr` = 0 and `rsp_kind` = 0.
- R11: Reset loads the default layout with enables clear. Window 0 is local 0x40 / PCI 0x40, 256 MB, kind 0. Window 1 is 0x50 / 0x50, 256 MB, kind 1. Window 2 is 0x60 / 0x60, 16 MB, kind 2. Setting an enable alone reveals that layout.
- R12: Register word layout, selected by `reg_sel`. When `reg_sel` = 0 (local), bits 12:5 are local address bits 31:24 and bit 0 is the enable. When `reg_sel` = 1 (translation), bits 12:5 are PCI address bits 31:24, bits 4:2 the kind and bits 1:0 the size code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_win | input | 2 | Window index of the write (3 = none) |
| reg_sel | input | 1 | 0 = local register, 1 = translation register |
| reg_wdata | input | 13 | Register write word |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local address to translate |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_win | output | 2 | Index of the winning window, 3 on miss |
| rsp_addr | output | 32 | Translated PCI address |
| rsp_kind | output | 3 | Access kind of the winning window |

## Verification
A wrong register value or a wrong priority shows up on the very next response. The symptoms are a wrong `rsp_win`, a wrong translated address, or a hit where a miss was due. A stale or wrong state in the response machine shows up as a response strobe on a cycle without a request, or as a miss carrying nonzero fields. The overlapping-window scenario exercises the priority order under each window size. The same-edge write case separates old register values from new ones within a single cycle.

// File: rtl/lbwin_pkg.sv
package lbwin_pkg;

    localparam int LB_AW   = 32;
    localparam int LB_GRAN = 24;
    localparam int LB_TAGW = LB_AW - LB_GRAN;
    localparam int LB_NWIN = 3;
    localparam int LB_KW   = 3;
    localparam int LB_DW   = LB_TAGW + LB_KW + 2;

    localparam logic [LB_KW-1:0] KIND_MEM   = 3'd0;
    localparam logic [LB_KW-1:0] KIND_MEMPF = 3'd1;
    localparam logic [LB_KW-1:0] KIND_IO    = 3'd2;
    localparam logic [LB_KW-1:0] KIND_CFG   = 3'd3;
    localparam logic [LB_KW-1:0] KIND_MSG   = 3'd4;

    typedef struct packed {
        logic               en;
        logic [LB_TAGW-1:0] lbase;
        logic [LB_TAGW-1:0] xbase;
        logic [1:0]         szc;
        logic [LB_KW-1:0]   kind;
    } win_cfg_t;

    // Mask over the upper address tag; cleared low bits lie inside the window.
    function automatic logic [LB_TAGW-1:0] tag_mask(input logic [1:0] szc,
                                                    input logic [LB_KW-1:0] kind);
        logic [LB_TAGW-1:0] m;
        int unsigned sh;
        m = '1;
        if (kind == KIND_CFG) begin
            sh = 0;
        end else begin
            unique case (szc)
                2'd0:    sh = 0;
                2'd1:    sh = 4;
                2'd2:    sh = 5;
                default: sh = 6;
            endcase
        end
        return m << sh;
    endfunction

    // Power-up layout: three consecutive windows, all disabled.
    function automatic win_cfg_t def_cfg(input int idx);
        win_cfg_t c;
        c.en    = 1'b0;
        c.lbase = LB_TAGW'(8'h40 + 8'(idx * 16));
        c.xbase = LB_TAGW'(8'h40 + 8'(idx * 16));
        c.szc   = (idx == LB_NWIN - 1) ? 2'd0 : 2'd1;
        c.kind  = (idx == 0) ? KIND_MEM : ((idx == 1) ? KIND_MEMPF : KIND_IO);
        return c;
    endfunction

endpackage

// File: rtl/lbwin_regs.sv
module lbwin_regs
    import lbwin_pkg::*;
#(
    parameter int NWIN = LB_NWIN,
    parameter int DW   = LB_DW,
    localparam int IDXW = $clog2(NWIN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IDXW-1:0] win,
    input  logic            sel,
    input  logic [DW-1:0]   wdata,
    output win_cfg_t        cfg_o [NWIN]
);

    localparam int KLO = 2;
    localparam int TLO = KLO + LB_KW;

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        logic [LB_KW-1:0] kind_in;

        if (i == NWIN - 1) begin : g_io_only
            // Last window carries only I/O or message-unit traffic.
            always_comb begin
                kind_in = wdata[TLO-1:KLO];
                if (kind_in != KIND_IO && kind_in != KIND_MSG) begin
                    kind_in = KIND_IO;
                end
            end
        end else begin : g_any
            always_comb kind_in = wdata[TLO-1:KLO];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[i] <= def_cfg(i);
            end else if (we && win == IDXW'(i)) begin
                if (!sel) begin
                    cfg_o[i].lbase <= wdata[DW-1:TLO];
                    cfg_o[i].en    <= wdata[0];
                end else begin
                    cfg_o[i].xbase <= wdata[DW-1:TLO];
                    cfg_o[i].kind  <= kind_in;
                    cfg_o[i].szc   <= wdata[1:0];
                end
            end
        end
    end

endmodule

// File: rtl/lbwin_match.sv
module lbwin_match
    import lbwin_pkg::*;
#(
    parameter int AW = LB_AW
) (
    input  win_cfg_t        cfg,
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [AW-1:0]   xaddr
);

    localparam int GRAN = AW - LB_TAGW;

    logic [LB_TAGW-1:0] mask;
    logic [AW-1:0]      full_mask;
    logic [AW-1:0]      xlat;

    always_comb begin
        mask      = tag_mask(cfg.szc, cfg.kind);
        full_mask = {mask, {GRAN{1'b0}}};
        hit       = cfg.en && ((addr[AW-1:GRAN] & mask) == (cfg.lbase & mask));
        xlat      = {cfg.xbase & mask, {GRAN{1'b0}}} | (addr & ~full_mask);
        if (cfg.kind == KIND_CFG) begin
            xlat[1:0] = 2'b00;
        end
        xaddr = xlat;
    end

endmodule

// File: rtl/lbwin_pick.sv
module lbwin_pick
    import lbwin_pkg::*;
#(
    parameter int NWIN = LB_NWIN,
    parameter int AW   = LB_AW,
    localparam int IDXW = $clog2(NWIN + 1)
) (
    input  logic [NWIN-1:0]  hits,
    input  logic [AW-1:0]    xaddrs [NWIN],
    input  logic [LB_KW-1:0] kinds  [NWIN],
    output logic             any,
    output logic [IDXW-1:0]  idx,
    output logic [AW-1:0]    addr,
    output logic [LB_KW-1:0] kind
);

    // Walk downward so that the lowest matching index is written last.
    always_comb begin
        any  = 1'b0;
        idx  = '1;
        addr = '0;
        kind = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any  = 1'b1;
                idx  = IDXW'(i);
                addr = xaddrs[i];
                kind = kinds[i];
            end
        end
    end

endmodule

// File: rtl/lbwin_xlate.sv
module lbwin_xlate
    import lbwin_pkg::*;
#(
    parameter int NWIN = LB_NWIN,
    parameter int AW   = LB_AW,
    parameter int DW   = LB_DW,
    localparam int IDXW = $clog2(NWIN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [IDXW-1:0]  reg_win,
    input  logic             reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDXW-1:0]  rsp_win,
    output logic [AW-1:0]    rsp_addr,
    output logic [LB_KW-1:0] rsp_kind
);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } rsp_state_t;

    win_cfg_t         cfg [NWIN];
    logic [NWIN-1:0]  hits;
    logic [AW-1:0]    xaddrs [NWIN];
    logic [LB_KW-1:0] kinds  [NWIN];
    logic             pk_any;
    logic [IDXW-1:0]  pk_idx;
    logic [AW-1:0]    pk_addr;
    logic [LB_KW-1:0] pk_kind;

    rsp_state_t       state_q, state_d;
    logic [IDXW-1:0]  idx_q;
    logic [AW-1:0]    addr_q;
    logic [LB_KW-1:0] kind_q;

    lbwin_regs #(.NWIN(NWIN), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .win   (reg_win),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .cfg_o (cfg)
    );

    for (genvar i = 0; i < NWIN; i++) begin : g_match
        lbwin_match #(.AW(AW)) u_match (
            .cfg   (cfg[i]),
            .addr  (req_addr),
            .hit   (hits[i]),
            .xaddr (xaddrs[i])
        );
        assign kinds[i] = cfg[i].kind;
    end

    lbwin_pick #(.NWIN(NWIN), .AW(AW)) u_pick (
        .hits   (hits),
        .xaddrs (xaddrs),
        .kinds  (kinds),
        .any    (pk_any),
        .idx    (pk_idx),
        .addr   (pk_addr),
        .kind   (pk_kind)
    );

    // Next-state decision: quiet / matched / unmatched, from every state.
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_HIT, ST_MISS: begin
                if (!req_valid)  state_d = ST_IDLE;
                else if (pk_any) state_d = ST_HIT;
                else             state_d = ST_MISS;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '1;
            addr_q  <= '0;
            kind_q  <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                idx_q  <= pk_idx;
                addr_q <= pk_addr;
                kind_q <= pk_kind;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_hit   = 1'b0;
        rsp_win   = '1;
        rsp_addr  = '0;
        rsp_kind  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HIT: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_win   = idx_q;
                rsp_addr  = addr_q;
                rsp_kind  = kind_q;
            end
            ST_MISS: rsp_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lbwin_xlate_chk.sv
module lbwin_xlate_chk
    import lbwin_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [1:0]       rsp_win,
    input logic [LB_AW-1:0] rsp_addr,
    input logic [LB_KW-1:0] rsp_kind
);

    p_resp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_quiet_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_hit);

    p_miss_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_win == 2'd3 && rsp_addr == '0 && rsp_kind == '0));

    p_hit_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_win != 2'd3));

    p_cfg_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_kind == KIND_CFG) |-> (rsp_addr[1:0] == 2'b00));

    p_win2_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && rsp_win == 2'd2) |-> (rsp_kind == KIND_IO || rsp_kind == KIND_MSG));

endmodule

bind lbwin_xlate lbwin_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_win   (rsp_win),
    .rsp_addr  (rsp_addr),
    .rsp_kind  (rsp_kind)
);

// File: tb/lbwin_xlate_tb.sv
`timescale 1ns/1ps
module lbwin_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_win = '0;
    logic        reg_sel = 1'b0;
    logic [12:0] reg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_win;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_kind;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        logic        hit;
        logic [1:0]  win;
        logic [31:0] addr;
        logic [2:0]  kind;
        string       tag;
    } exp_t;

    exp_t sb[$];

    // Bench-side register image, built from the requirements.
    logic       m_en [3];
    logic [7:0] m_lb [3];
    logic [7:0] m_xb [3];
    logic [1:0] m_sz [3];
    logic [2:0] m_kd [3];

    always #2.5 clk = ~clk;

    lbwin_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_win(reg_win),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_win(rsp_win), .rsp_addr(rsp_addr), .rsp_kind(rsp_kind)
    );

    function automatic logic [7:0] b_mask(input logic [1:0] sz, input logic [2:0] kd);
        if (kd == 3'd3) return 8'hFF;
        case (sz)
            2'd0: return 8'hFF;
            2'd1: return 8'hF0;
            2'd2: return 8'hE0;
            default: return 8'hC0;
        endcase
    endfunction

    function automatic exp_t model(input logic [31:0] a, input string tag);
        exp_t e;
        e.hit = 0; e.win = 2'd3; e.addr = '0; e.kind = '0; e.tag = tag;
        for (int w = 2; w >= 0; w--) begin
            logic [7:0] mk;
            mk = b_mask(m_sz[w], m_kd[w]);
            if (m_en[w] && ((a[31:24] & mk) == (m_lb[w] & mk))) begin
                e.hit  = 1;
                e.win  = 2'(w);
                e.kind = m_kd[w];
                e.addr = {m_xb[w] & mk, 24'h0} | (a & ~{mk, 24'h0});
                if (m_kd[w] == 3'd3) e.addr[1:0] = 2'b00;
            end
        end
        return e;
    endfunction

    task automatic model_write(input int w, input bit sel, input logic [12:0] d);
        if (w > 2) return;
        if (!sel) begin
            m_lb[w] = d[12:5];
            m_en[w] = d[0];
        end else begin
            m_xb[w] = d[12:5];
            m_sz[w] = d[1:0];
            m_kd[w] = d[4:2];
            if (w == 2 && d[4:2] != 3'd2 && d[4:2] != 3'd4) m_kd[w] = 3'd2;
        end
    endtask

    task automatic wr(input int w, input bit sel, input logic [12:0] d);
        @(negedge clk);
        req_valid = 0;
        reg_we = 1; reg_win = 2'(w); reg_sel = sel; reg_wdata = d;
        model_write(w, sel, d);
    endtask

    task automatic send(input logic [31:0] a, input string tag);
        @(negedge clk);
        reg_we = 0;
        req_valid = 1; req_addr = a;
        sb.push_back(model(a, tag));
    endtask

    // Write and request on the same edge: the request sees the old image.
    task automatic wr_send(input int w, input bit sel, input logic [12:0] d,
                           input logic [31:0] a, input string tag);
        @(negedge clk);
        sb.push_back(model(a, tag));
        reg_we = 1; reg_win = 2'(w); reg_sel = sel; reg_wdata = d;
        req_valid = 1; req_addr = a;
        model_write(w, sel, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            reg_we = 0; req_valid = 0;
        end
    endtask

    function automatic logic [12:0] lw(input logic [7:0] tag, input bit en);
        return {tag, 4'b0, en};
    endfunction

    function automatic logic [12:0] mw(input logic [7:0] tag, input logic [2:0] kd,
                                       input logic [1:0] sz);
        return {tag, kd, sz};
    endfunction

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2: response with no pending request, actual win=%0d expected none",
                         rsp_win);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_win !== e.win || rsp_addr !== e.addr ||
                    rsp_kind !== e.kind) begin
                    n_fail++;
                    $display("FAIL %s: actual hit=%0b win=%0d addr=%h kind=%0d expected hit=%0b win=%0d addr=%h kind=%0d",
                             e.tag, rsp_hit, rsp_win, rsp_addr, rsp_kind,
                             e.hit, e.win, e.addr, e.kind);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still going expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 3; w++) begin
            m_en[w] = 0;
            m_lb[w] = 8'(8'h40 + w * 16);
            m_xb[w] = 8'(8'h40 + w * 16);
            m_sz[w] = (w == 2) ? 2'd0 : 2'd1;
            m_kd[w] = 3'(w);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        n_chk++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual rsp_valid=%0b expected 0", rsp_valid);
        end
        // R1 / R10: everything disabled after reset
        send(32'h4000_1234, "R1_reset_miss");
        // R11 / R3 / R12: enabling reveals the default layout
        wr(0, 0, lw(8'h40, 1));
        send(32'h4000_1234, "R11_win0_default");
        wr(1, 0, lw(8'h50, 1));
        wr(2, 0, lw(8'h60, 1));
        send(32'h5ABC_DEF0, "R11_win1_default");
        send(32'h60FF_FFFC, "R11_win2_default");
        send(32'h6100_0000, "R3_past_win2_end");
        send(32'h3FFF_FFFF, "R3_below_win0");
        send(32'h4FFF_FFFF, "R3_win0_top");
        // R4 / R5 / R6: enlarge window 0 to 512 MB over window 1
        wr(0, 1, mw(8'h80, 3'd0, 2'd2));
        send(32'h5ABC_DEF0, "R4_win0_hides_win1");
        send(32'h4000_0004, "R5_offset_or");
        // R7: window 1 reprogrammed as 16 MB configuration window
        wr(1, 1, mw(8'h00, 3'd3, 2'd1));
        wr(1, 0, lw(8'h61, 1));
        send(32'h6100_1A17, "R7_cfg_fields");
        send(32'h61FF_FFFF, "R7_cfg_top");
        send(32'h6200_0000, "R7_cfg_16mb_only");
        // R8: window 2 kind restriction
        wr(2, 1, mw(8'h60, 3'd0, 2'd0));
        send(32'h6000_0010, "R8_mem_forced_io");
        wr(2, 1, mw(8'h60, 3'd4, 2'd0));
        send(32'h6000_0010, "R8_msg_kept");
        wr(2, 1, mw(8'h60, 3'd3, 2'd0));
        send(32'h6000_0013, "R8_cfg_forced_io");
        // R9: same-edge write uses old values, later requests the new ones
        wr_send(0, 0, lw(8'h40, 0), 32'h4000_0010, "R9_same_edge_old");
        send(32'h4000_0010, "R9_next_edge_new");
        send(32'h5ABC_DEF0, "R9_win1_moved");
        wr(3, 0, lw(8'h40, 1));
        send(32'h4000_0010, "R9_index3_ignored");
        // R6 / R4: 1 GB window 0 over window 1
        wr(0, 1, mw(8'hC0, 3'd0, 2'd3));
        wr(0, 0, lw(8'h40, 1));
        send(32'h7FFF_FFF0, "R6_1gb_top");
        send(32'h8000_0000, "R6_1gb_end");
        send(32'h6100_0000, "R4_1gb_over_cfg");
        idle(4);
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: actual %0d responses missing expected 0", sb.size());
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule